// File: doc/BRIEF.md
# In-Service Interrupt Priority Controller

This block collects a set of peripheral interrupt request lines and hands the CPU one vector number at a time, together with a one-cycle valid pulse. It keeps an in-service register with one bit per vector. The in-service register records which handlers the CPU has been given and has not yet finished. A request reaches the CPU only when it outranks every vector still in service. Lower vector numbers carry higher priority.

The CPU unwinds the in-service state with end-of-interrupt (EOI) messages. A non-specific message retires the highest-priority vector in service. A specific message names the vector to retire. A specific message that carries the all-ones number is reserved and is dropped.

Each vector also has a mode bit. A vector in legacy mode never enters the in-service register. Its peripheral acknowledge waits for an explicit CPU acknowledge of that vector. A vector in EOI mode is acknowledged to its peripheral in the same cycle it is forwarded.

Top module: `irq_isr_ctrl`

## Requirements
- R1: When an EOI-mode vector is forwarded, its in-service bit is set at the same clock edge that raises `fwd_valid` for one cycle with `fwd_vec` equal to the vector number.
- R2: A request is forwarded only if its vector number is strictly lower than the lowest-numbered bit set in the in-service register. When the register is empty, any vector may be forwarded.
- R3: A vector whose in-service bit is set is not forwarded again until that bit is cleared.
- R4: A non-specific EOI (`eoi_valid`=1, `eoi_specific`=0) clears only the lowest-numbered set bit of the in-service register.
- R5: A specific EOI (`eoi_valid`=1, `eoi_specific`=1) clears exactly the in-service bit numbered `eoi_vec` and leaves every other bit unchanged.
- R6: A vector whose `irq_legacy` bit is 1 sets no in-service bit when forwarded. It gets no peripheral acknowledge at forward time. Its `irq_ack` bit pulses one cycle after a `cpu_ack_valid` whose `cpu_ack_vec` names it. The vector is not forwarded again while it awaits that acknowledge.
- R7: For an EOI-mode vector, the `irq_ack` bit of that vector pulses in the same cycle as its `fwd_valid`.
- R8: A specific EOI whose `eoi_vec` is all ones (255 for the default 8-bit width) clears no in-service bit.
- R9: A rising request edge seen while the vector's `irq_mask` bit is 1 is not latched. A masked vector is never forwarded.
- R10: A pending bit is latched at the clock edge that first samples the request high after it was low, and it clears when the vector is forwarded. The forward appears one edge after the latch. Among eligible pending vectors, the lowest number is forwarded first.
- R11: An EOI that arrives in the same cycle as a forward decision is applied before that decision, so a request unblocked by the EOI is forwarded at that same edge.
- R12: A non-specific EOI received while the in-service register is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_VEC | Peripheral request lines, bit i is vector i |
| irq_mask | input | NUM_VEC | 1 blocks the vector |
| irq_legacy | input | NUM_VEC | 1 selects acknowledge-handshake mode for the vector |
| eoi_valid | input | 1 | End-of-interrupt message strobe |
| eoi_specific | input | 1 | 1: message names a vector in `eoi_vec`; 0: non-specific |
| eoi_vec | input | ID_W | Vector named by a specific EOI |
| cpu_ack_valid | input | 1 | CPU acknowledge strobe for a legacy vector |
| cpu_ack_vec | input | ID_W | Vector the CPU acknowledges |
| irq_ack | output | NUM_VEC | Per-vector peripheral acknowledge pulse |
| fwd_valid | output | 1 | One-cycle pulse: a vector is offered to the CPU |
| fwd_vec | output | ID_W | Vector number offered to the CPU |

## Verification
The hardest case to reach from the ports is an EOI that lands in the same cycle as a forward decision. Two conditions must hold at once: a lower-priority request must already be latched and blocked by the in-service state, and the EOI must remove exactly the bit that blocks it. The stimulus table builds this up in order. It first forwards a high-priority vector. It then raises a lower-priority request and holds it for a cycle so the block can be observed. Only then does it issue the EOI, and it expects the blocked vector at that same edge. The same staging, with two in-service bits set, separates a specific EOI that clears only its own bit from one that clears too much. It also catches a reserved all-ones EOI that wrongly releases a held vector.

// File: rtl/irq_isr_pkg.sv
package irq_isr_pkg;

  typedef enum logic [1:0] {
    EOI_NONE     = 2'd0,
    EOI_LOWEST   = 2'd1,
    EOI_TARGET   = 2'd2,
    EOI_RESERVED = 2'd3
  } eoi_kind_e;

  // Sort an incoming end-of-interrupt message into the action it asks for.
  function automatic eoi_kind_e eoi_classify(input logic valid,
                                             input logic specific,
                                             input logic all_ones);
    if (!valid)         return EOI_NONE;
    else if (!specific) return EOI_LOWEST;
    else if (all_ones)  return EOI_RESERVED;
    else                return EOI_TARGET;
  endfunction

endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Scan from the top so the last hit written is the lowest index.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
  parameter int NUM_VEC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] req,
  input  logic [NUM_VEC-1:0] mask,
  input  logic [NUM_VEC-1:0] take,
  output logic [NUM_VEC-1:0] pend_q
);
  logic [NUM_VEC-1:0] req_q;
  logic [NUM_VEC-1:0] rise;

  // Only an unmasked low-to-high change of the raw line counts.
  assign rise = req & ~req_q & ~mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req;
      pend_q <= (pend_q | rise) & ~take;
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
  import irq_isr_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int ID_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eoi_valid,
  input  logic               eoi_specific,
  input  logic [ID_W-1:0]    eoi_vec,
  input  logic [NUM_VEC-1:0] set_bits,
  output logic [NUM_VEC-1:0] isr_q,
  output logic [NUM_VEC-1:0] isr_eff
);
  eoi_kind_e          kind;
  logic [NUM_VEC-1:0] lowest_bit;
  logic [NUM_VEC-1:0] target_bit;
  logic [NUM_VEC-1:0] eoi_clr;

  assign kind       = eoi_classify(eoi_valid, eoi_specific, &eoi_vec);
  // Two's-complement trick isolates the lowest set bit.
  assign lowest_bit = isr_q & (~isr_q + NUM_VEC'(1));

  genvar g;
  generate
    for (g = 0; g < NUM_VEC; g++) begin : g_tgt
      assign target_bit[g] = (eoi_vec == ID_W'(g));
    end
  endgenerate

  always_comb begin
    unique case (kind)
      EOI_LOWEST: eoi_clr = lowest_bit;
      EOI_TARGET: eoi_clr = target_bit;
      default:    eoi_clr = '0;
    endcase
  end

  // State seen by this cycle's forward decision: the EOI is already applied.
  assign isr_eff = isr_q & ~eoi_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_eff | set_bits;
  end
endmodule

// File: rtl/irq_isr_ctrl.sv
module irq_isr_ctrl
  import irq_isr_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int ID_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_req,
  input  logic [NUM_VEC-1:0] irq_mask,
  input  logic [NUM_VEC-1:0] irq_legacy,
  input  logic               eoi_valid,
  input  logic               eoi_specific,
  input  logic [ID_W-1:0]    eoi_vec,
  input  logic               cpu_ack_valid,
  input  logic [ID_W-1:0]    cpu_ack_vec,
  output logic [NUM_VEC-1:0] irq_ack,
  output logic               fwd_valid,
  output logic [ID_W-1:0]    fwd_vec
);
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] pend_q;
  logic [NUM_VEC-1:0] isr_q;
  logic [NUM_VEC-1:0] isr_eff;
  logic [NUM_VEC-1:0] wait_q;
  logic [NUM_VEC-1:0] below_ceil;
  logic [NUM_VEC-1:0] eligible;
  logic [NUM_VEC-1:0] take_bit;
  logic [NUM_VEC-1:0] take_isr;
  logic [NUM_VEC-1:0] take_leg;
  logic [NUM_VEC-1:0] cpu_ack_hit;
  logic               ceil_found;
  logic [IDX_W-1:0]   ceil_idx;
  logic               take_found;
  logic [IDX_W-1:0]   take_idx;

  irq_pend_capture #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (irq_req),
    .mask  (irq_mask),
    .take  (take_bit),
    .pend_q(pend_q)
  );

  irq_inservice #(.NUM_VEC(NUM_VEC), .ID_W(ID_W)) u_isr (
    .clk         (clk),
    .rst_n       (rst_n),
    .eoi_valid   (eoi_valid),
    .eoi_specific(eoi_specific),
    .eoi_vec     (eoi_vec),
    .set_bits    (take_isr),
    .isr_q       (isr_q),
    .isr_eff     (isr_eff)
  );

  // Priority ceiling: the highest-priority vector still in service.
  irq_lowest_pick #(.W(NUM_VEC), .IW(IDX_W)) u_ceil (
    .vec  (isr_eff),
    .found(ceil_found),
    .idx  (ceil_idx)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_VEC; g++) begin : g_vec
      assign below_ceil[g]  = !ceil_found || (IDX_W'(g) < ceil_idx);
      assign cpu_ack_hit[g] = cpu_ack_valid && (cpu_ack_vec == ID_W'(g)) && wait_q[g];
    end
  endgenerate

  assign eligible = pend_q & ~irq_mask & ~isr_eff & ~wait_q & below_ceil;

  irq_lowest_pick #(.W(NUM_VEC), .IW(IDX_W)) u_take (
    .vec  (eligible),
    .found(take_found),
    .idx  (take_idx)
  );

  assign take_bit = eligible & (~eligible + NUM_VEC'(1));
  assign take_isr = take_bit & ~irq_legacy;
  assign take_leg = take_bit & irq_legacy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_vec   <= '0;
      irq_ack   <= '0;
      wait_q    <= '0;
    end else begin
      fwd_valid <= take_found;
      fwd_vec   <= take_found ? ID_W'(take_idx) : '0;
      irq_ack   <= take_isr | cpu_ack_hit;
      wait_q    <= (wait_q | take_leg) & ~cpu_ack_hit;
    end
  end
endmodule

// File: rtl/irq_isr_ctrl_chk.sv
module irq_isr_ctrl_chk #(
  parameter int NUM_VEC = 16,
  parameter int ID_W    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_VEC-1:0] irq_legacy,
  input logic               eoi_valid,
  input logic               eoi_specific,
  input logic [ID_W-1:0]    eoi_vec,
  input logic               fwd_valid,
  input logic [ID_W-1:0]    fwd_vec,
  input logic [NUM_VEC-1:0] irq_ack,
  input logic [NUM_VEC-1:0] isr_q
);
  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] leg_prev;
  logic [NUM_VEC-1:0] higher_than_fwd;
  logic [IDX_W-1:0]   fwd_idx;

  assign fwd_idx = fwd_vec[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) leg_prev <= '0;
    else        leg_prev <= irq_legacy;
  end

  always_comb begin
    for (int i = 0; i < NUM_VEC; i++) higher_than_fwd[i] = (IDX_W'(i) < fwd_idx);
  end

  assert_fwd_sets_isr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !leg_prev[fwd_idx] |-> isr_q[fwd_idx]);

  assert_fwd_outranks_isr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ((isr_q & higher_than_fwd) == '0));

  assert_legacy_no_isr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && leg_prev[fwd_idx] |-> !isr_q[fwd_idx] && !irq_ack[fwd_idx]);

  assert_ack_with_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !leg_prev[fwd_idx] |-> irq_ack[fwd_idx]);

  assert_reserved_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid && eoi_specific && (&eoi_vec) |=> (($past(isr_q) & ~isr_q) == '0));

  assert_empty_eoi_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid && !eoi_specific && (isr_q == '0) |=> ($countones(isr_q) <= 1));
endmodule

bind irq_isr_ctrl irq_isr_ctrl_chk #(.NUM_VEC(NUM_VEC), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_legacy  (irq_legacy),
  .eoi_valid   (eoi_valid),
  .eoi_specific(eoi_specific),
  .eoi_vec     (eoi_vec),
  .fwd_valid   (fwd_valid),
  .fwd_vec     (fwd_vec),
  .irq_ack     (irq_ack),
  .isr_q       (isr_q)
);

// File: tb/irq_isr_ctrl_bench.sv
module irq_isr_ctrl_bench;
  localparam int N  = 16;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0, irq_mask = '0, irq_legacy = '0;
  logic          eoi_valid = 1'b0, eoi_specific = 1'b0;
  logic [IW-1:0] eoi_vec = '0;
  logic          cpu_ack_valid = 1'b0;
  logic [IW-1:0] cpu_ack_vec = '0;
  logic [N-1:0]  irq_ack;
  logic          fwd_valid;
  logic [IW-1:0] fwd_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_isr_ctrl #(.NUM_VEC(N), .ID_W(IW)) u_irq_isr_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
    .irq_legacy(irq_legacy), .eoi_valid(eoi_valid), .eoi_specific(eoi_specific),
    .eoi_vec(eoi_vec), .cpu_ack_valid(cpu_ack_valid), .cpu_ack_vec(cpu_ack_vec),
    .irq_ack(irq_ack), .fwd_valid(fwd_valid), .fwd_vec(fwd_vec)
  );

  // eoi: 0 none, 1 non-specific, 2 specific. Expectations hold after the edge
  // that follows the row's inputs.
  typedef struct packed {
    logic [15:0] req, mask, leg;
    logic [1:0]  eoi;
    logic [7:0]  ev;
    logic        ca;
    logic [7:0]  cav;
    logic        efv;
    logic [7:0]  evec;
    logic [15:0] eack;
    logic [3:0]  rq;
  } row_t;

  localparam int ROWS = 42;
  localparam row_t TBL [ROWS] = '{
    '{16'h0000,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd10}, // R10 idle
    '{16'h0020,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd10}, // R10 latch 5
    '{16'h0020,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b1,8'd5,16'h0020,4'd1},  // R1 R7 fwd 5
    '{16'h0020,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd10}, // R10 pend cleared
    '{16'h0120,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd10},
    '{16'h0120,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd2},  // R2 8 blocked by 5
    '{16'h0121,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd2},
    '{16'h0121,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b1,8'd0,16'h0001,4'd2},  // R2 0 preempts
    '{16'h0121,16'h0,16'h0,2'd1,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd4},  // R4 clears 0 only
    '{16'h0121,16'h0,16'h0,2'd2,8'd5,1'b0,8'd0,1'b1,8'd8,16'h0100,4'd11}, // R11 R5 same cycle
    '{16'h0000,16'h0,16'h0,2'd2,8'hFF,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd8}, // R8 reserved
    '{16'h0100,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd3},
    '{16'h0100,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd3},  // R3 R8 8 still held
    '{16'h0100,16'h0,16'h0,2'd2,8'd8,1'b0,8'd0,1'b1,8'd8,16'h0100,4'd3},  // R3 released
    '{16'h0000,16'h0,16'h0,2'd1,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd4},
    '{16'h0000,16'h0,16'h0,2'd1,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd12}, // R12 empty EOI
    '{16'h0004,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd12},
    '{16'h0004,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b1,8'd2,16'h0004,4'd12},
    '{16'h0006,16'h2,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd9},  // R9 masked edge
    '{16'h0006,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd9},
    '{16'h0006,16'h0,16'h0,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd9},  // R9 never latched
    '{16'h0004,16'h0,16'h8,2'd1,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd6},
    '{16'h000C,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd6},
    '{16'h000C,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b1,8'd3,16'h0000,4'd6},  // R6 no ack yet
    '{16'h000C,16'h0,16'h8,2'd0,8'd0,1'b1,8'd3,1'b0,8'd0,16'h0008,4'd6},  // R6 ack after CPU
    '{16'h000C,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd6},
    '{16'h001C,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd6},
    '{16'h001C,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b1,8'd4,16'h0010,4'd6},  // R6 no isr bit 3
    '{16'h0000,16'h0,16'h8,2'd2,8'd4,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd5},
    '{16'h0A00,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd10},
    '{16'h0A00,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b1,8'd9,16'h0200,4'd10}, // R10 lowest wins
    '{16'h0A00,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd2},
    '{16'h0A00,16'h0,16'h8,2'd2,8'd9,1'b0,8'd0,1'b1,8'd11,16'h0800,4'd11},// R11
    '{16'h0000,16'h0,16'h8,2'd1,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd4},
    '{16'h0002,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd10},
    '{16'h0002,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b1,8'd1,16'h0002,4'd1},
    '{16'h0003,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd10},
    '{16'h0003,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b1,8'd0,16'h0001,4'd2},
    '{16'h0803,16'h0,16'h8,2'd2,8'd1,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd5},
    '{16'h0803,16'h0,16'h8,2'd0,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd5},  // R5 bit 0 kept
    '{16'h0803,16'h0,16'h8,2'd2,8'd0,1'b0,8'd0,1'b1,8'd11,16'h0800,4'd5},
    '{16'h0000,16'h0,16'h8,2'd1,8'd0,1'b0,8'd0,1'b0,8'd0,16'h0000,4'd4}
  };

  task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    irq_req       = r.req;
    irq_mask      = r.mask;
    irq_legacy    = r.leg;
    eoi_valid     = (r.eoi != 2'd0);
    eoi_specific  = (r.eoi == 2'd2);
    eoi_vec       = r.ev;
    cpu_ack_valid = r.ca;
    cpu_ack_vec   = r.cav;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(10, "reset fwd_valid", 32'(fwd_valid), 32'd0);
    check(10, "reset irq_ack", 32'(irq_ack), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < ROWS; i++) begin
      drive(TBL[i]);
      @(posedge clk);
      #1;
      check(TBL[i].rq, $sformatf("row %0d fwd_valid", i), 32'(fwd_valid), 32'(TBL[i].efv));
      if (TBL[i].efv)
        check(TBL[i].rq, $sformatf("row %0d fwd_vec", i), 32'(fwd_vec), 32'(TBL[i].evec));
      check(TBL[i].rq, $sformatf("row %0d irq_ack", i), 32'(irq_ack), 32'(TBL[i].eack));
      @(negedge clk);
    end

    // Directed: reset with vector 2 in service, then vector 15 must pass (R2, R10).
    irq_req = 16'h0004; irq_legacy = '0; eoi_valid = 1'b0; cpu_ack_valid = 1'b0;
    repeat (3) @(negedge clk);
    irq_req = 16'h0000;
    rst_n = 1'b0;
    @(negedge clk);
    check(1, "mid reset fwd_valid", 32'(fwd_valid), 32'd0);
    rst_n = 1'b1;
    irq_req = 16'h8000;
    @(negedge clk);
    check(10, "vec15 latch only", 32'(fwd_valid), 32'd0);
    @(negedge clk);
    check(2, "vec15 after reset fwd_valid", 32'(fwd_valid), 32'd1);
    check(2, "vec15 after reset fwd_vec", 32'(fwd_vec), 32'd15);
    check(7, "vec15 ack", 32'(irq_ack), 32'h8000);

    // Directed: held masked pending is not forwarded (R9).
    irq_req = 16'h0000;
    eoi_valid = 1'b1; eoi_specific = 1'b1; eoi_vec = 8'd15;
    @(negedge clk);
    eoi_valid = 1'b0;
    irq_req = 16'h0040;
    @(negedge clk);
    irq_mask = 16'h0040;
    @(negedge clk);
    check(9, "masked pending held back", 32'(fwd_valid), 32'd0);
    irq_mask = 16'h0000;
    @(negedge clk);
    check(9, "unmasked pending fwd_vec", 32'(fwd_valid ? fwd_vec : 8'hEE), 32'd6);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule